// File: doc/BRIEF.md
# Two-Master Pipelined Bus Arbiter

This block lets several masters (two by default) share one system bus that has a single slave behind it. A master raises its request line and waits for its grant. While granted, it presents an address, a direction and its write data. The arbiter forwards the address phase of the granted master to the slave. When the slave accepts it, the transfer moves into a one-cycle data phase, and the next address phase is presented in that same cycle. The address of one transfer therefore overlaps the data of the one before it.

The slave can hold its ready input low. While it does, the data phase in progress and the pending address phase both stay frozen, and the grant does not move. Ownership rotates round-robin on every accepted address phase, so masters that keep requesting take turns. When no master requests, the grant parks on the last owner and the bus shows an idle transfer. Completion and read data go back to the master that issued the matching address phase, even if the grant has already moved on.

Top module: `bus_share_arbiter`

## Requirements
- R1: During reset and in the first cycle after it, the grant is one-hot on master 0, the bus shows an idle transfer (`s_trans_o` = 0), and no completion is signalled.
- R2: `m_gnt_o` has exactly one bit set in every cycle.
- R3: When the granted master has its request high, `s_trans_o` is 1, and `s_addr_o` and `s_write_o` carry that master's address and direction (1 = write). Otherwise `s_trans_o`, `s_addr_o` and `s_write_o` are all 0.
- R4: An address phase is accepted in a cycle where `s_trans_o` and `s_ready_i` are both 1. The next cycle is its data phase. For a write, `s_wdata_o` carries the write data the master presented together with the address. Outside a write data phase, `s_wdata_o` is 0.
- R5: In a data phase, `m_done_o[i]` is 1 exactly when master i issued that phase and `s_ready_i` is 1. For a read, `m_rdata_o[i]` carries `s_rdata_i` to that master throughout the data phase. `m_rdata_o` is 0 for every other master.
- R6: While `s_ready_i` is 0, the grant and the data phase in progress (owner, direction, write data) hold unchanged into the next cycle.
- R7: On each cycle with `s_ready_i` = 1, the grant moves to the first requesting master after the current owner in ascending cyclic order. The current owner itself comes last in that search. With two masters that both keep requesting, the grant alternates.
- R8: When no master requests, the grant stays on the last owner.
- R9: The grant changes only at a clock edge where `s_ready_i` was 1.
- R10: With the default parameters, the address and data buses are 16 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| m_req_i | input | N | Per-master bus request |
| m_gnt_o | output | N | One-hot bus grant |
| m_addr_i | input | N x AW | Per-master address |
| m_write_i | input | N | Per-master direction, 1 = write |
| m_wdata_i | input | N x DW | Per-master write data, presented with the address |
| m_done_o | output | N | Data phase of that master completes this cycle |
| m_rdata_o | output | N x DW | Read data routed to the data-phase owner |
| s_trans_o | output | 1 | Address phase active (1) or idle (0) |
| s_addr_o | output | AW | Slave address |
| s_write_o | output | 1 | Slave direction |
| s_wdata_o | output | DW | Slave write data in the data phase |
| s_rdata_i | input | DW | Slave read data |
| s_ready_i | input | 1 | Slave ready; low stalls both phases |

## Verification
The hardest case to reach is a stall that lands right at an ownership change. Here master A's data phase is frozen while master B's address phase waits, and completion must still go to A. To get there, the bench keeps both masters requesting continuously and drives ready from a pseudo-random pattern. This makes stalls fall on both sides of many grant hand-offs. A behavioural model that tracks owner, data-phase owner and direction is compared against every output on every clock. A final phase, in which nothing is requested, lets the pipeline drain and shows the grant parking.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  typedef enum logic {
    TR_IDLE = 1'b0,
    TR_XFER = 1'b1
  } trans_e;
endpackage

// File: rtl/bsa_rr_arbiter.sv
module bsa_rr_arbiter #(
  parameter int N  = 2,
  parameter int IW = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          advance_i,
  output logic [IW-1:0] owner_o,
  output logic [N-1:0]  gnt_o
);
  logic [IW-1:0] owner_q, owner_d;

  // search starts after the owner; the owner itself is tried last
  always_comb begin
    logic found;
    owner_d = owner_q;
    found   = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int idx;
      idx = (int'(owner_q) + k) % N;
      if (!found && req_i[idx]) begin
        owner_d = IW'(idx);
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        owner_q <= '0;
    else if (advance_i) owner_q <= owner_d;
  end

  assign owner_o = owner_q;

  for (genvar g = 0; g < N; g++) begin : g_gnt
    assign gnt_o[g] = (owner_q == IW'(g));
  end
endmodule

// File: rtl/bsa_addr_mux.sv
module bsa_addr_mux
  import bsa_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = 1,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic [IW-1:0]        owner_i,
  input  logic [N-1:0]         req_i,
  input  logic [N-1:0][AW-1:0] addr_i,
  input  logic [N-1:0]         write_i,
  input  logic [N-1:0][DW-1:0] wdata_i,
  output trans_e               trans_o,
  output logic [AW-1:0]        addr_o,
  output logic                 write_o,
  output logic [DW-1:0]        wdata_o
);
  logic active;

  assign active  = req_i[owner_i];
  assign trans_o = active ? TR_XFER : TR_IDLE;
  assign addr_o  = active ? addr_i[owner_i] : '0;
  assign write_o = active & write_i[owner_i];
  assign wdata_o = wdata_i[owner_i];
endmodule

// File: rtl/bsa_data_phase.sv
module bsa_data_phase
  import bsa_pkg::*;
#(
  parameter int N  = 2,
  parameter int IW = 1,
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ready_i,
  input  trans_e               trans_i,
  input  logic [IW-1:0]        owner_i,
  input  logic                 write_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [DW-1:0]        rdata_i,
  output logic                 valid_o,
  output logic [DW-1:0]        wdata_o,
  output logic [N-1:0]         done_o,
  output logic [N-1:0][DW-1:0] rdata_o
);
  logic          valid_q, write_q;
  logic [IW-1:0] owner_q;
  logic [DW-1:0] wdata_q;

  // ready low freezes the stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      write_q <= 1'b0;
      owner_q <= '0;
      wdata_q <= '0;
    end else if (ready_i) begin
      valid_q <= (trans_i == TR_XFER);
      if (trans_i == TR_XFER) begin
        owner_q <= owner_i;
        write_q <= write_i;
        wdata_q <= wdata_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign wdata_o = (valid_q && write_q) ? wdata_q : '0;

  for (genvar g = 0; g < N; g++) begin : g_ret
    logic mine;
    assign mine       = valid_q && (owner_q == IW'(g));
    assign done_o[g]  = mine && ready_i;
    assign rdata_o[g] = (mine && !write_q) ? rdata_i : '0;
  end
endmodule

// File: rtl/bus_share_arbiter.sv
module bus_share_arbiter
  import bsa_pkg::*;
#(
  parameter int N  = 2,
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         m_req_i,
  output logic [N-1:0]         m_gnt_o,
  input  logic [N-1:0][AW-1:0] m_addr_i,
  input  logic [N-1:0]         m_write_i,
  input  logic [N-1:0][DW-1:0] m_wdata_i,
  output logic [N-1:0]         m_done_o,
  output logic [N-1:0][DW-1:0] m_rdata_o,
  output logic                 s_trans_o,
  output logic [AW-1:0]        s_addr_o,
  output logic                 s_write_o,
  output logic [DW-1:0]        s_wdata_o,
  input  logic [DW-1:0]        s_rdata_i,
  input  logic                 s_ready_i
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] owner;
  trans_e        trans;
  logic [DW-1:0] ap_wdata;
  logic          dp_valid;

  bsa_rr_arbiter #(.N(N), .IW(IW)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (m_req_i),
    .advance_i (s_ready_i),
    .owner_o   (owner),
    .gnt_o     (m_gnt_o)
  );

  bsa_addr_mux #(.N(N), .IW(IW), .AW(AW), .DW(DW)) u_amux (
    .owner_i (owner),
    .req_i   (m_req_i),
    .addr_i  (m_addr_i),
    .write_i (m_write_i),
    .wdata_i (m_wdata_i),
    .trans_o (trans),
    .addr_o  (s_addr_o),
    .write_o (s_write_o),
    .wdata_o (ap_wdata)
  );

  bsa_data_phase #(.N(N), .IW(IW), .DW(DW)) u_dp (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (s_ready_i),
    .trans_i (trans),
    .owner_i (owner),
    .write_i (s_write_o),
    .wdata_i (ap_wdata),
    .rdata_i (s_rdata_i),
    .valid_o (dp_valid),
    .wdata_o (s_wdata_o),
    .done_o  (m_done_o),
    .rdata_o (m_rdata_o)
  );

  assign s_trans_o = (trans == TR_XFER);
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker #(
  parameter int N = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [N-1:0] m_req_i,
  input logic [N-1:0] m_gnt_o,
  input logic [N-1:0] m_done_o,
  input logic         s_trans_o,
  input logic         s_ready_i,
  input logic         dp_valid
);
  a_r2_grant_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(m_gnt_o));

  a_r9_grant_hold_on_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_i |=> $stable(m_gnt_o));

  a_r6_data_phase_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_ready_i |=> $stable(dp_valid));

  a_r4_data_follows_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_trans_o && s_ready_i) |=> dp_valid);

  a_r5_single_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(m_done_o));

  a_r7_rotate_all_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_i && (&m_req_i)) |=> (m_gnt_o != $past(m_gnt_o)));

  a_r8_park_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_ready_i && (m_req_i == '0)) |=> $stable(m_gnt_o));
endmodule

bind bus_share_arbiter bsa_checker #(.N(N)) u_bsa_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .m_req_i   (m_req_i),
  .m_gnt_o   (m_gnt_o),
  .m_done_o  (m_done_o),
  .s_trans_o (s_trans_o),
  .s_ready_i (s_ready_i),
  .dp_valid  (dp_valid)
);

// File: tb/bus_share_arbiter_test.sv
module bus_share_arbiter_test;
  localparam int CLK_P = 10;
  localparam int N = 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [N-1:0]         m_req = '0;
  logic [N-1:0]         m_gnt;
  logic [N-1:0][15:0]   m_addr = '0;
  logic [N-1:0]         m_write = '0;
  logic [N-1:0][15:0]   m_wdata = '0;
  logic [N-1:0]         m_done;
  logic [N-1:0][15:0]   m_rdata;
  logic                 s_trans, s_write;
  logic [15:0]          s_addr, s_wdata;
  logic [15:0]          s_rdata = '0;
  logic                 s_ready = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int owner, dv, downer, dwrite;
  logic [15:0] dwdata;
  int cnt[N];
  int left[N];
  logic [7:0] lfsr = 8'h5b;
  string gtag = "R7";

  always #(CLK_P/2) clk = ~clk;

  bus_share_arbiter uut (
    .clk_i(clk), .rst_ni(rst_n),
    .m_req_i(m_req), .m_gnt_o(m_gnt),
    .m_addr_i(m_addr), .m_write_i(m_write), .m_wdata_i(m_wdata),
    .m_done_o(m_done), .m_rdata_o(m_rdata),
    .s_trans_o(s_trans), .s_addr_o(s_addr), .s_write_o(s_write),
    .s_wdata_o(s_wdata), .s_rdata_i(s_rdata), .s_ready_i(s_ready)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic drive(input bit stall);
    for (int i = 0; i < N; i++) begin
      m_req[i]   = left[i] > 0;
      m_addr[i]  = 16'(i * 16'h4000 + cnt[i] * 4);
      m_write[i] = cnt[i][0];
      m_wdata[i] = m_addr[i] ^ 16'ha5c3;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    s_ready = stall ? (lfsr[0] | lfsr[2]) : 1'b1;
    s_rdata = {lfsr, ~lfsr};
  endtask

  task automatic compare();
    int ex_trans;
    ex_trans = m_req[owner];
    chk(gtag, "grant", 32'(m_gnt), 32'(1 << owner));
    chk("R2", "grant onehot", 32'($countones(m_gnt)), 32'd1);
    chk("R3", "trans", 32'(s_trans), 32'(ex_trans));
    chk("R3", "addr", 32'(s_addr), ex_trans ? 32'(m_addr[owner]) : 32'd0);
    chk("R3", "write", 32'(s_write), ex_trans ? 32'(m_write[owner]) : 32'd0);
    chk("R4", "wdata", 32'(s_wdata), (dv && dwrite) ? 32'(dwdata) : 32'd0);
    for (int i = 0; i < N; i++) begin
      chk("R5", "done", 32'(m_done[i]), 32'(dv && s_ready && downer == i));
      chk("R5", "rdata", 32'(m_rdata[i]), (dv && !dwrite && downer == i) ? 32'(s_rdata) : 32'd0);
    end
  endtask

  task automatic advance_model();
    int ex_trans;
    ex_trans = m_req[owner];
    if (s_ready) begin
      dv = ex_trans;
      if (ex_trans) begin
        downer = owner;
        dwrite = m_write[owner];
        dwdata = m_wdata[owner];
        cnt[owner]++;
        left[owner]--;
      end
      for (int k = N; k >= 1; k--) begin
        if (m_req[(owner + k) % N]) owner = (owner + k) % N;
      end
    end
  endtask

  task automatic run(input int ncyc, input bit stall);
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      drive(stall);
      #1;
      compare();
      @(posedge clk);
      advance_model();
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    owner = 0; dv = 0; downer = 0; dwrite = 0; dwdata = '0;
    for (int i = 0; i < N; i++) begin cnt[i] = 0; left[i] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "reset grant", 32'(m_gnt), 32'd1);
    chk("R1", "reset trans", 32'(s_trans), 32'd0);
    chk("R1", "reset done", 32'(m_done), 32'd0);
    chk("R1", "reset wdata", 32'(s_wdata), 32'd0);
    chk("R10", "addr width", 32'($bits(s_addr)), 32'd16);
    chk("R10", "data width", 32'($bits(s_wdata)), 32'd16);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "post-reset grant", 32'(m_gnt), 32'd1);
    chk("R1", "post-reset trans", 32'(s_trans), 32'd0);
    @(posedge clk);

    gtag = "R7"; left[0] = 6;               run(10, 0);  // back-to-back, one master
    left[0] = 8; left[1] = 8;               run(20, 0);  // alternation
    gtag = "R6"; left[0] = 12; left[1] = 12; run(70, 1); // stalls across hand-offs
    gtag = "R8"; left[0] = 0; left[1] = 0;  run(8, 0);   // drain and park
    gtag = "R9"; left[1] = 6;               run(40, 1);
    gtag = "R8"; left[0] = 0; left[1] = 0;  run(6, 1);

    finished = 1;
    summary();
    $finish;
  end
endmodule